// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block sits on a simple synchronous register bus and controls one successive-approximation analog-to-digital converter with several multiplexed inputs. Software writes a control word that powers the converter, picks an input and enables the interrupt. The block waits a programmable settling time, then finds the result one bit per clock, starting at the most significant bit. It drives a trial code and a channel number to an external DAC/comparator pair and reads one comparator bit back each cycle. When the last bit is known, the result goes into the data register, the busy flag drops and an interrupt status flag is raised. Software clears the flag, and powers the converter down, by writing zero to the control register.

The sequencer has four named states. `ST_IDLE` waits for a start. `ST_SETTLE` counts down the programmed delay. `ST_TRIAL` resolves one bit per cycle. `ST_DONE` latches the result for one cycle.

The transitions are:
- IDLE→SETTLE on a control write with power set.
- SETTLE→TRIAL when the delay count is zero.
- TRIAL→DONE after the least significant bit.
- DONE→IDLE unconditionally.
- Any state→SETTLE on a control write with power set (restart).
- Any state→IDLE on a control write with power clear (abort).

Top module: `sar_adc_ctl`

## Requirements
- R1: After reset, all of the following hold: data reads 0, status reads 0, control reads 0, the delay register reads 8, `irq` is 0 and `adc_pwr` is 0.
- R2: The word index is `reg_addr[3:2]`, and the registers are as follows.
  - Index 0 is data.
  - Index 1 is status, with bit 0 set while busy.
  - Index 2 is control:
    - bits 2:0 select the channel;
    - bit 3 is power;
    - bit 5 is interrupt enable;
    - bit 6 is interrupt status.
  - Index 3 is the delay register.
  - Control bits 2:0, 3 and 5 read back as written, and bit 4 and bits 31:7 read 0.
- R3: A control write with bit 3 set starts a conversion. Status bit 0 reads 1 for exactly delay+RES_W+2 cycles after the write edge.
- R4: The delay register keeps only bits 5:0 of a write. The settling phase lasts delay+1 cycles, so a delay of 0 gives the shortest conversion.
- R5: The search runs from MSB to LSB. `dac_code` equals the bits kept so far plus the bit under trial, and the trial bit is kept when `cmp_in` is 1 (input at or above `dac_code`). The result is the largest code that does not exceed the input.
- R6: The data register holds the result in bits RES_W-1:0, and its upper bits read 0. It keeps the last result until the next conversion completes.
- R7: Control bit 6 is set in the cycle the result is latched. `irq` is high exactly when bit 6 and bit 5 are both 1.
- R8: A control write with bit 3 clear has three effects:
  - it aborts any conversion, so busy reads 0 on the next cycle;
  - it drops `adc_pwr`;
  - it leaves data unchanged.
  Writing 0 also clears bit 6 and drops `irq`. Software can never set bit 6.
- R9: A control write with bit 3 set during a conversion restarts it from the settling phase. The latency is counted from the new write, and the channel is the newly selected one.
- R10: A channel select of NCH or above reads back as written but converts channel 0 (`dac_chan` is 0).
- R11: A control write with bit 3 clear while idle starts nothing: busy stays 0 and `adc_pwr` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address; bits 3:2 select the word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| adc_pwr | output | 1 | Converter power enable |
| dac_chan | output | 3 | Input channel for the analog multiplexer |
| dac_code | output | RES_W | Trial code for the DAC; 0 outside the trial phase |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |

## Verification
The bench builds the block with RES_W=10 and NCH=3. With these values, the control field's selects 3 to 7 are out-of-range channels that the bench can exercise, and the 10-bit search can reach an all-zero, an all-one and a clamped result. A behavioural comparator in the bench compares a per-channel input value with `dac_code`. The bench uses delays of 0, 3, 8 and the masked value 63, so the measured busy window covers the shortest, typical and longest settling phases.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_TRIAL  = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;

    // word indices (reg_addr[3:2])
    localparam int unsigned W_DATA = 0;
    localparam int unsigned W_STAT = 1;
    localparam int unsigned W_CTRL = 2;
    localparam int unsigned W_DLY  = 3;

    // control field positions
    localparam int unsigned B_PWR  = 3;
    localparam int unsigned B_IE   = 5;
    localparam int unsigned B_ST   = 6;
    localparam int unsigned CH_W   = 3;
    localparam int unsigned DLY_W  = 6;
    localparam int unsigned DLY_RST = 8;

endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int unsigned RES_W = 10,
    parameter int unsigned NCH   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             pwr_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic [CH_W-1:0]  chan_sel_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic [CH_W-1:0]  chan_o
);
    localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] ONE     = RES_W'(1);

    seq_state_t       state_q, state_d;
    logic [DLY_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] acc_q;
    logic [CH_W-1:0]  chan_q;
    logic [RES_W-1:0] trial;
    logic [CH_W-1:0]  chan_map;

    assign trial    = acc_q | (ONE << idx_q);
    assign chan_map = (32'(chan_sel_i) < NCH) ? chan_sel_i : '0;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SETTLE;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SETTLE: if (cnt_q == '0) state_d = ST_TRIAL;
                ST_TRIAL:  if (idx_q == '0) state_d = ST_DONE;
                ST_DONE:   state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            acc_q  <= '0;
            chan_q <= '0;
        end else if (start_i) begin
            cnt_q  <= dly_i;
            idx_q  <= IDX_TOP;
            acc_q  <= '0;
            chan_q <= chan_map;
        end else begin
            unique case (state_q)
                ST_SETTLE: if (cnt_q != '0) cnt_q <= cnt_q - DLY_W'(1);
                ST_TRIAL: begin
                    if (cmp_i)        acc_q <= trial;
                    if (idx_q != '0)  idx_q <= idx_q - IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE) && !start_i && !stop_i;
        result_o   = acc_q;
        dac_code_o = (state_q == ST_TRIAL) ? trial : '0;
        chan_o     = chan_q;
    end

    // R8: the converter never runs unpowered
    p_busy_needs_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> pwr_i);

    // R4: settling counts down by one each cycle
    p_settle_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && cnt_q != '0 && !start_i && !stop_i)
        |=> (state_q == ST_SETTLE && cnt_q == $past(cnt_q) - DLY_W'(1)));

    // R5: first trial code is the MSB alone
    p_first_trial_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && cnt_q == '0 && !start_i && !stop_i)
        |=> (dac_code_o == (ONE << IDX_TOP)));

    // R5: every trial code has the trial bit set
    p_trial_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL) |-> (dac_code_o != '0));

    // R10: channel driven to the converter is always in range
    p_chan_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (32'(chan_o) < NCH));

endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [RES_W-1:0]  result_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              pwr_o,
    output logic              irq_o,
    output logic [CH_W-1:0]   chan_sel_o,
    output logic [DLY_W-1:0]  dly_o
);
    logic [1:0]       word;
    logic             ctrl_wr;
    logic [RES_W-1:0] data_q;
    logic [CH_W-1:0]  chan_q;
    logic             pwr_q, ie_q, st_q;
    logic [DLY_W-1:0] dly_q;
    logic             unused_bits;

    assign word        = addr_i[3:2];
    assign ctrl_wr     = wr_i && (word == 2'(W_CTRL));
    assign unused_bits = ^{addr_i, wdata_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            chan_q <= '0;
            pwr_q  <= 1'b0;
            ie_q   <= 1'b0;
            st_q   <= 1'b0;
            dly_q  <= DLY_W'(DLY_RST);
        end else begin
            if (done_i) data_q <= result_i;
            if (ctrl_wr) begin
                chan_q <= wdata_i[CH_W-1:0];
                pwr_q  <= wdata_i[B_PWR];
                ie_q   <= wdata_i[B_IE];
                st_q   <= st_q & wdata_i[B_ST];
            end else if (done_i) begin
                st_q   <= 1'b1;
            end
            if (wr_i && word == 2'(W_DLY)) dly_q <= wdata_i[DLY_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (word)
            2'(W_DATA): rdata_o = DATA_W'(data_q);
            2'(W_STAT): rdata_o = DATA_W'(busy_i);
            2'(W_CTRL): begin
                rdata_o[CH_W-1:0] = chan_q;
                rdata_o[B_PWR]    = pwr_q;
                rdata_o[B_IE]     = ie_q;
                rdata_o[B_ST]     = st_q;
            end
            default:    rdata_o = DATA_W'(dly_q);
        endcase
    end

    assign start_o    = ctrl_wr &&  wdata_i[B_PWR];
    assign stop_o     = ctrl_wr && !wdata_i[B_PWR];
    assign pwr_o      = pwr_q;
    assign irq_o      = st_q & ie_q;
    assign chan_sel_o = chan_q;
    assign dly_o      = dly_q;

    // R7: status rises only after a completed conversion
    p_status_from_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q) |-> $past(done_i));

    // R6: data only changes on completion
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(data_q));

    // R8: a control write of zero leaves no pending interrupt
    p_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata_i == '0) |=> (!irq_o && !pwr_o));

endmodule

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl
    import sar_adc_pkg::*;
#(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned NCH    = 6,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              adc_pwr,
    output logic [CH_W-1:0]   dac_chan,
    output logic [RES_W-1:0]  dac_code,
    input  logic              cmp_in
);
    logic             start, stop, busy, done;
    logic [RES_W-1:0] result;
    logic [CH_W-1:0]  chan_sel;
    logic [DLY_W-1:0] dly;

    sar_adc_regs #(.RES_W(RES_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .busy_i     (busy),
        .done_i     (done),
        .result_i   (result),
        .start_o    (start),
        .stop_o     (stop),
        .pwr_o      (adc_pwr),
        .irq_o      (irq),
        .chan_sel_o (chan_sel),
        .dly_o      (dly)
    );

    sar_adc_seq #(.RES_W(RES_W), .NCH(NCH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .stop_i     (stop),
        .pwr_i      (adc_pwr),
        .dly_i      (dly),
        .chan_sel_i (reg_wdata[CH_W-1:0]),
        .cmp_i      (cmp_in),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result),
        .dac_code_o (dac_code),
        .chan_o     (dac_chan)
    );

    // R3: busy drops only through completion or an abort write
    p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(done) || $past(stop)));

    logic unused_sel;
    assign unused_sel = ^chan_sel;

endmodule

// File: tb/sar_adc_ctl_test.sv
module sar_adc_ctl_test;
    localparam int CLK_NS = 10;
    localparam int RW     = 10;
    localparam int NC     = 3;
    localparam int MAXV   = (1 << RW) - 1;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq, adc_pwr, cmp_in;
    logic [2:0]  dac_chan;
    logic [RW-1:0] dac_code;
    int          ain [0:7];
    int          errs = 0;
    int          checks = 0;
    int          cur_dly = 8;

    always #(CLK_NS/2) clk = ~clk;

    assign cmp_in = (ain[dac_chan] >= int'(dac_code));

    sar_adc_ctl #(.RES_W(RW), .NCH(NC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .adc_pwr(adc_pwr), .dac_chan(dac_chan), .dac_code(dac_code),
        .cmp_in(cmp_in)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        reg_addr = 4'(idx << 2); reg_wdata = 32'(val); reg_wr = 1;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input int idx, output int val);
        reg_addr = 4'(idx << 2); #1;
        val = int'(reg_rdata);
    endtask

    // counts cycles with busy set after a write, until it clears
    task automatic busy_len(output int n);
        int v;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); rd(1, v);
            if (v[0]) n++; else break;
        end
    endtask

    task automatic t_reset;
        int v;
        rd(0, v); chk("R1 data", v, 0);
        rd(1, v); chk("R1 status", v, 0);
        rd(2, v); chk("R1 ctrl", v, 0);
        rd(3, v); chk("R1 delay", v, 8);
        chk("R1 irq", irq, 0);
        chk("R1 pwr", adc_pwr, 0);
    endtask

    task automatic t_regmap;
        int v;
        wr(3, 32'hFF); rd(3, v); chk("R4 delay mask", v, 32'h3F);
        wr(3, 8);
        wr(2, 32'hFFFF_FF37); // no power bit
        @(negedge clk); rd(1, v); chk("R11 no start", v, 0);
        chk("R11 pwr", adc_pwr, 0);
        rd(2, v); chk("R2 ctrl readback", v, 32'h27);
        wr(2, 0);
    endtask

    task automatic t_convert(input int ch, input int val, input int dly, input int ie);
        int v, n, exp;
        exp = (val > MAXV) ? MAXV : val;
        wr(3, dly); cur_dly = dly;
        ain[ch] = val;
        wr(2, 32'h08 | (ie << 5) | ch);
        busy_len(n);
        chk("R3/R4 busy cycles", n, dly + RW + 2);
        rd(0, v); chk("R5/R6 result", v, exp);
        rd(2, v); chk("R7 status set", (v >> 6) & 1, 1);
        chk("R7 irq", irq, ie);
        chk("R8 pwr held", adc_pwr, 1);
        wr(2, 0);
        @(negedge clk);
        chk("R8 irq cleared", irq, 0);
        chk("R8 pwr down", adc_pwr, 0);
        rd(2, v); chk("R8 ctrl zero", v, 0);
        rd(0, v); chk("R6 data held", v, exp);
    endtask

    task automatic t_restart;
        int v, n;
        ain[1] = 100; ain[2] = 777;
        wr(3, 8);
        wr(2, 32'h29);
        repeat (12) @(negedge clk);
        wr(2, 32'h2A);
        busy_len(n);
        chk("R9 restart cycles", n, 8 + RW + 2);
        rd(0, v); chk("R9 new channel result", v, 777);
        wr(2, 0);
        // abort with power cleared
        wr(2, 32'h29);
        repeat (5) @(negedge clk);
        wr(2, 0);
        @(negedge clk); rd(1, v); chk("R8 abort busy", v, 0);
        repeat (30) @(negedge clk);
        rd(0, v); chk("R8 abort keeps data", v, 777);
        rd(2, v); chk("R8 abort no status", v, 0);
    endtask

    task automatic t_chanmap;
        int v, n;
        ain[0] = 32'h123; ain[5] = 5;
        wr(3, 3);
        wr(2, 32'h2D);
        rd(2, v); chk("R10 readback", v & 7, 5);
        @(negedge clk); #1;
        chk("R10 dac_chan", dac_chan, 0);
        busy_len(n);
        rd(0, v); chk("R10 converts ch0", v, 32'h123);
        wr(2, 0);
    endtask

    task automatic t_trace;
        // R5: observe first trial codes for input 0x200
        int seen;
        ain[1] = 32'h200;
        wr(3, 0);
        wr(2, 32'h09);
        @(negedge clk); #1; // settle cycle
        @(negedge clk); #1; seen = int'(dac_code);
        chk("R5 first trial MSB", seen, 32'h200);
        @(negedge clk); #1; seen = int'(dac_code);
        chk("R5 second trial keeps MSB", seen, 32'h300);
        repeat (20) @(negedge clk);
        wr(2, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ain[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_convert(0, 32'h2AA, 8, 1);
        t_convert(1, 0, 0, 1);
        t_convert(2, MAXV, 3, 1);
        t_convert(2, 2000, 63, 0);
        t_convert(1, 32'h200, 8, 0);
        t_restart();
        t_chanmap();
        t_trace();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule